// File: doc/BRIEF.md
# Windowed Internal RAM Addressing Unit

This unit owns a 256-byte on-chip scratch RAM that a processor treats as a large, relocatable register file. Two 8-bit pointer registers steer every access. The window base selects where the default register window sits. The index register offers a second, movable reference point. A request gives an 8-bit operand and an addressing mode that an instruction decoder has already resolved from any prefix byte. From these the unit forms an effective RAM address and moves one, two or three bytes between the RAM and the request port.

A request is presented on `reqValid` with mode, operand, width, direction and write data. The unit captures the effective address when it accepts the request. It then transfers one byte per clock, lowest byte first at the effective address. It raises `done` for a single cycle once the last byte has been handled. For reads, the assembled value appears on `rdData` at that point. Software relocates the default window by loading a new window base. A program can therefore give each routine a private register area without changing its operands.

Top module: `iram_window_unit`

## Requirements
- R1: After reset the window base and index register are both zero, `done` is low and `rdData` is zero; RAM contents are undefined until written.
- R2: With `reqMode` = 2'd0 (window-relative), operand n addresses location (base + n) mod 256.
- R3: With `reqMode` = 2'd1 (absolute), operand n addresses location n and the window base has no effect.
- R4: With `reqMode` = 2'd2 (index-relative), operand n addresses location (index + n) mod 256.
- R5: With `reqMode` = 2'd3 (base plus index), the address is (base + index) mod 256 and the operand value has no effect.
- R6: `reqWidth` 2'd1, 2'd2 and 2'd3 move that many bytes, and 2'd0 moves one byte. Values are little-endian: byte k sits at bits [8k+7:8k] of `reqWrData`/`rdData` and at effective address + k. On a read, the bytes of `rdData` above the width are zero.
- R7: Byte addresses of a multi-byte access wrap from 255 to 0.
- R8: A request is accepted at a rising edge where `reqValid` is high and no access is in progress. For a W-byte access, `done` is high for exactly the one cycle that follows the W-th rising edge after acceptance, and it is low otherwise.
- R9: While an access is in progress, `reqValid` is ignored; no RAM location other than the in-flight access's is written. A request may be accepted in the cycle where `done` is high.
- R10: `bpLoad`/`pxLoad` load the window base/index at the next rising edge. A loaded value is used only by requests accepted after that edge. A load during an access does not move that access, and a load at the accepting edge does not affect the request being accepted.
- R11: `rdData` keeps its value from the last completed read until the next read is accepted; writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 2 | Addressing mode: 0 window, 1 absolute, 2 index, 3 base plus index |
| reqOperand | input | 8 | Operand offset or absolute location |
| reqWidth | input | 2 | Byte count (0 treated as 1) |
| reqWrData | input | 24 | Little-endian write value |
| bpLoad | input | 1 | Load strobe for the window base |
| bpData | input | 8 | New window base |
| pxLoad | input | 1 | Load strobe for the index register |
| pxData | input | 8 | New index value |
| rdData | output | 24 | Little-endian read value, unused high bytes zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are the collisions with an access in flight. These are a pointer load that lands between the bytes of a three-byte access, a load on the same edge as acceptance, and a second request held high while the first is still moving bytes. Directed sequences place each of these on a precise edge. Afterwards, reads through the absolute mode show that only the intended locations changed. Randomized mode, width, operand and pointer-load mixes then run against a byte-level model of the RAM, including windows placed near the top so that accesses wrap.

// File: rtl/iwu_pkg.sv
package iwu_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 3;
  localparam int LANE_W    = $clog2(MAX_BYTES);
  localparam int DATA_W    = BYTE_W * MAX_BYTES;

  typedef enum logic [1:0] {
    MODE_WIN     = 2'd0,
    MODE_ABS     = 2'd1,
    MODE_IDX     = 2'd2,
    MODE_BASEIDX = 2'd3
  } addrMode_e;

  typedef struct packed {
    logic              accept;
    logic              clrRd;
    logic              wrEn;
    logic              rdEn;
    logic [LANE_W-1:0] laneIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/iwu_ctrl.sv
module iwu_ctrl
  import iwu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqWidth,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  logic [LANE_W-1:0] laneCnt;
  logic [LANE_W-1:0] lastLane;
  logic              isWrite;
  logic              accept;
  logic [LANE_W-1:0] reqLast;

  assign accept  = reqValid & ~busy;
  assign reqLast = (reqWidth == 2'd0) ? '0 : LANE_W'(reqWidth - 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      laneCnt  <= '0;
      lastLane <= '0;
      isWrite  <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      laneCnt  <= '0;
      lastLane <= reqLast;
      isWrite  <= reqWrite;
    end else if (busy) begin
      if (laneCnt == lastLane) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        laneCnt <= laneCnt + 1'b1;
        done    <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  always_comb begin
    strobe.accept  = accept;
    strobe.clrRd   = accept & ~reqWrite;
    strobe.wrEn    = busy & isWrite;
    strobe.rdEn    = busy & ~isWrite;
    strobe.laneIdx = laneCnt;
  end
endmodule

// File: rtl/iwu_datapath.sv
module iwu_datapath
  import iwu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] reqOperand,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              bpLoad,
  input  logic [ADDR_W-1:0] bpData,
  input  logic              pxLoad,
  input  logic [ADDR_W-1:0] pxData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] bpQ,
  output logic [ADDR_W-1:0] pxQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem     [DEPTH];
  logic [BYTE_W-1:0] wrLanes [MAX_BYTES];
  logic [BYTE_W-1:0] rdLanes [MAX_BYTES];
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [BYTE_W-1:0] memRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ <= '0;
      pxQ <= '0;
    end else begin
      if (bpLoad) bpQ <= bpData;
      if (pxLoad) pxQ <= pxData;
    end
  end

  always_comb begin
    unique case (addrMode_e'(reqMode))
      MODE_WIN:     effAddr = bpQ + reqOperand;
      MODE_ABS:     effAddr = reqOperand;
      MODE_IDX:     effAddr = pxQ + reqOperand;
      MODE_BASEIDX: effAddr = bpQ + pxQ;
      default:      effAddr = reqOperand;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseAddr <= '0;
    else if (strobe.accept) baseAddr <= effAddr;
  end

  assign curAddr = baseAddr + ADDR_W'(strobe.laneIdx);
  assign memRd   = mem[curAddr];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[curAddr] <= wrLanes[strobe.laneIdx];
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrLanes[g] <= '0;
        rdLanes[g] <= '0;
      end else begin
        if (strobe.accept) wrLanes[g] <= reqWrData[g*BYTE_W +: BYTE_W];
        if (strobe.clrRd) rdLanes[g] <= '0;
        else if (strobe.rdEn && strobe.laneIdx == LANE_W'(g)) rdLanes[g] <= memRd;
      end
    end
    assign rdData[g*BYTE_W +: BYTE_W] = rdLanes[g];
  end
endmodule

// File: rtl/iram_window_unit.sv
module iram_window_unit
  import iwu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] reqOperand,
  input  logic [1:0]        reqWidth,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              bpLoad,
  input  logic [ADDR_W-1:0] bpData,
  input  logic              pxLoad,
  input  logic [ADDR_W-1:0] pxData,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  ctrlStrobe_t       strobe;
  logic              busy;
  logic              accept;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] bpQ;
  logic [ADDR_W-1:0] pxQ;

  assign accept = strobe.accept;

  iwu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWidth (reqWidth),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  iwu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqMode    (reqMode),
    .reqOperand (reqOperand),
    .reqWrData  (reqWrData),
    .bpLoad     (bpLoad),
    .bpData     (bpData),
    .pxLoad     (pxLoad),
    .pxData     (pxData),
    .rdData     (rdData),
    .baseAddr   (baseAddr),
    .bpQ        (bpQ),
    .pxQ        (pxQ)
  );
endmodule

// File: rtl/iram_window_chk.sv
module iram_window_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              busy,
  input logic              accept,
  input logic [1:0]        reqMode,
  input logic [ADDR_W-1:0] reqOperand,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] bpQ,
  input logic [ADDR_W-1:0] pxQ
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(baseAddr)); // R10

  AST_WIN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == 2'd0) |=> baseAddr == ADDR_W'($past(bpQ) + $past(reqOperand))); // R2

  AST_ABS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == 2'd1) |=> baseAddr == $past(reqOperand)); // R3

  AST_IDX_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == 2'd2) |=> baseAddr == ADDR_W'($past(pxQ) + $past(reqOperand))); // R4

  AST_BASEIDX_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMode == 2'd3) |=> baseAddr == ADDR_W'($past(bpQ) + $past(pxQ))); // R5
endmodule

bind iram_window_unit iram_window_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .done       (done),
  .busy       (busy),
  .accept     (accept),
  .reqMode    (reqMode),
  .reqOperand (reqOperand),
  .baseAddr   (baseAddr),
  .bpQ        (bpQ),
  .pxQ        (pxQ)
);

// File: tb/iram_window_unit_tb.sv
`timescale 1ns/1ps
module iram_window_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqMode = 2'd0;
  logic [7:0]  reqOperand = 8'd0;
  logic [1:0]  reqWidth = 2'd1;
  logic [23:0] reqWrData = 24'd0;
  logic        bpLoad = 1'b0;
  logic [7:0]  bpData = 8'd0;
  logic        pxLoad = 1'b0;
  logic [7:0]  pxData = 8'd0;
  logic [23:0] rdData;
  logic        done;

  int checks = 0;
  int fails = 0;
  logic [7:0]  memM [256];
  logic [7:0]  bpM = 8'd0;
  logic [7:0]  pxM = 8'd0;
  logic [23:0] lastRd = 24'd0;

  always #5 clk = ~clk;

  iram_window_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMode(reqMode), .reqOperand(reqOperand), .reqWidth(reqWidth),
    .reqWrData(reqWrData), .bpLoad(bpLoad), .bpData(bpData),
    .pxLoad(pxLoad), .pxData(pxData), .rdData(rdData), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] effAddr(input logic [1:0] mode, input logic [7:0] op);
    case (mode)
      2'd0:    return bpM + op;
      2'd1:    return op;
      2'd2:    return pxM + op;
      default: return bpM + pxM;
    endcase
  endfunction

  function automatic int nBytes(input logic [1:0] w);
    return (w == 2'd0) ? 1 : int'(w);
  endfunction

  task automatic loadPtr(input bit isBp, input logic [7:0] v);
    @(negedge clk);
    if (isBp) begin bpLoad = 1'b1; bpData = v; end
    else begin pxLoad = 1'b1; pxData = v; end
    @(negedge clk);
    bpLoad = 1'b0; pxLoad = 1'b0;
    if (isBp) bpM = v; else pxM = v;
  endtask

  task automatic access(input logic [1:0] mode, input logic [7:0] op, input logic [1:0] w,
                        input bit wr, input logic [23:0] data, input bit sameLoad,
                        input bit midLoad, input logic [7:0] ldVal, input string req);
    logic [7:0]  a;
    logic [23:0] exp;
    int n;
    n = nBytes(w);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMode = mode; reqOperand = op;
    reqWidth = w; reqWrData = data;
    a = effAddr(mode, op);
    if (sameLoad) begin bpLoad = 1'b1; bpData = ldVal; bpM = ldVal; end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; bpLoad = 1'b0;
    check(done == 1'b0, "R8 done low during access", 24'(done), 24'd0);
    if (midLoad) begin bpLoad = 1'b1; bpData = ldVal; bpM = ldVal; end
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      bpLoad = 1'b0;
    end
    check(done == 1'b1, "R8 done after last byte", 24'(done), 24'd1);
    exp = 24'd0;
    for (int k = 0; k < n; k++) begin
      if (wr) memM[8'(a + 8'(k))] = data[k*8 +: 8];
      else exp[k*8 +: 8] = memM[8'(a + 8'(k))];
    end
    if (wr) begin
      check(rdData == lastRd, "R11 rdData held across write", rdData, lastRd);
    end else begin
      check(rdData == exp, req, rdData, exp);
      lastRd = exp;
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", 24'(done), 24'd0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done low after reset", 24'(done), 24'd0);
    check(rdData == 24'd0, "R1 rdData zero after reset", rdData, 24'd0);
    rstN = 1'b1;
    for (int i = 0; i < 256; i++)
      access(2'd1, 8'(i), 2'd1, 1'b1, 24'($urandom), 1'b0, 1'b0, 8'd0, "R3");

    // R1: pointers start at zero
    access(2'd0, 8'h10, 2'd1, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R1 window base zero");
    access(2'd2, 8'h20, 2'd1, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R1 index zero");
    access(2'd3, 8'h77, 2'd2, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R1 base plus index zero");

    loadPtr(1'b1, 8'hF0);
    loadPtr(1'b0, 8'h33);
    access(2'd0, 8'h20, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R2 window read");
    access(2'd0, 8'h0E, 2'd3, 1'b1, 24'hA1B2C3, 1'b0, 1'b0, 8'd0, "R7");
    access(2'd1, 8'hFE, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R7 wrap read through 255");
    access(2'd1, 8'h05, 2'd2, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R3 absolute ignores base");
    access(2'd2, 8'hD0, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R4 index wrap read");
    access(2'd3, 8'h00, 2'd2, 1'b1, 24'h00BEEF, 1'b0, 1'b0, 8'd0, "R5");
    access(2'd3, 8'h9C, 2'd2, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R5 operand ignored");
    access(2'd1, 8'h40, 2'd0, 1'b1, 24'hFFFF5A, 1'b0, 1'b0, 8'd0, "R6");
    access(2'd1, 8'h40, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R6 width0 writes one byte");
    access(2'd1, 8'h40, 2'd0, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R6 width0 reads one byte, upper zero");
    access(2'd1, 8'h41, 2'd2, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R6 width2 upper byte zero");
    access(2'd1, 8'h50, 2'd1, 1'b1, 24'h000011, 1'b0, 1'b0, 8'd0, "R11");

    // R10: load in the middle of an access and on the accepting edge
    access(2'd0, 8'h08, 2'd3, 1'b1, 24'h123456, 1'b0, 1'b1, 8'h60, "R10");
    access(2'd1, 8'hF8, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R10 mid-access load did not move write");
    access(2'd0, 8'h08, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R10 new base used next request");
    access(2'd0, 8'h02, 2'd2, 1'b0, 24'd0, 1'b1, 1'b0, 8'h90, "R10 same-edge load uses old base");
    access(2'd0, 8'h02, 2'd2, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R10 same-edge load applies after");

    // R9: second request held high while first is in progress
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqMode = 2'd1; reqOperand = 8'h30;
    reqWidth = 2'd3; reqWrData = 24'h0BADF0;
    @(posedge clk);
    @(negedge clk);
    reqOperand = 8'h80; reqWidth = 2'd1; reqWrData = 24'h0000AA;
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R9 first access completes", 24'(done), 24'd1);
    memM[8'h30] = 8'hF0; memM[8'h31] = 8'hAD; memM[8'h32] = 8'h0B;
    access(2'd1, 8'h80, 2'd1, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R9 ignored request wrote nothing");
    access(2'd1, 8'h30, 2'd3, 1'b0, 24'd0, 1'b0, 1'b0, 8'd0, "R9 first access data");

    // Randomized mix
    for (int t = 0; t < 400; t++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) loadPtr(1'b1, 8'($urandom));
      else if (r == 1) loadPtr(1'b0, 8'($urandom));
      access(2'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 24'($urandom),
             1'b0, 1'b0, 8'd0, "R6 random access");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'd1, 24'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule